// File: doc/BRIEF.md
# Block-Transfer Mailbox Window (controller side)

This block is the controller-side register window of a byte-wide block-transfer mailbox. A host on a small byte bus sees three registers. Offset 0 holds the handshake flags and the control strobes. Offset 1 is a data port into two message buffers. Offset 2 is an interrupt-mask register. The host streams a request into the host-to-controller buffer and streams the response back out of the controller-to-host buffer. Each buffer has its own sequential pointer, and the host can reset either pointer through a strobe bit.

Local controller logic sits on the other side. It reads request bytes by address and sees how many bytes the host has written. It loads response bytes by address, and it raises or drops its own handshake flags. Each flag has its own write rule. Writing 1 toggles some flags, sets others and clears others. Writing 0 never changes anything. The two pointer-reset bits are strobes that always read back as 0. Because of this the status register can never read 0xFF.

Top module: `bt_window`

## Requirements
- R1: After reset, every flag is 0, both pointers are 0, the mask register is 0, the host read data is 0x00 and `ctl_hw_reset` is 0.
- R2: Offset 0 reads as {B_BUSY, H_BUSY, OEM0, SMS_ATN, B2H_ATN, H2B_ATN, 0, 0} from bit 7 down to bit 0. Bits 1 and 0 always read 0, so offset 0 never reads 0xFF. A 0 written to any bit of offset 0 changes nothing.
- R3: A host write with bit 6 = 1 to offset 0 toggles H_BUSY.
- R4: A host write with bit 2 = 1 sets H2B_ATN, and a `ctl_clr_h2b` pulse clears it. When both happen in the same cycle, the host set wins.
- R5: B2H_ATN (bit 3), SMS_ATN (bit 4) and OEM0 (bit 5) are set by their controller pulses and cleared by a host write of 1 to their bit. When both happen in the same cycle, the controller set wins.
- R6: B_BUSY (bit 7) is set by `ctl_set_bbusy` and cleared by `ctl_clr_bbusy`. Host writes have no effect on it.
- R7: A host write to offset 1 stores the byte at the host-to-controller pointer and advances the pointer. `ctl_h2b_count` equals the pointer, and `ctl_h2b_data` returns the byte stored at `ctl_h2b_addr` in the same cycle.
- R8: A host read of offset 1 returns the controller-to-host byte at the read pointer on `host_rdata` one cycle later, and advances the pointer. The controller loads that buffer with `ctl_c2h_we`, `ctl_c2h_addr` and `ctl_c2h_data`.
- R9: A host write to offset 0 with bit 0 = 1 resets the host-to-controller pointer to 0. A write with bit 1 = 1 resets the controller-to-host pointer to 0.
- R10: Pointers stop at DEPTH (64) and do not wrap. Host data writes beyond that point are dropped. Host data reads at that point return 0x00.
- R11: Offset 2 is a read/write 8-bit mask register, and its bit 7 drives `ctl_hw_reset`.
- R12: Offset 3 reads 0x00, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid the cycle after a read |
| ctl_set_b2h | input | 1 | Controller sets B2H_ATN |
| ctl_set_sms | input | 1 | Controller sets SMS_ATN |
| ctl_set_oem | input | 1 | Controller sets OEM0 |
| ctl_set_bbusy | input | 1 | Controller sets B_BUSY |
| ctl_clr_bbusy | input | 1 | Controller clears B_BUSY |
| ctl_clr_h2b | input | 1 | Controller clears H2B_ATN |
| ctl_h2b_addr | input | 6 | Request buffer read address |
| ctl_h2b_data | output | 8 | Request byte at `ctl_h2b_addr` |
| ctl_h2b_count | output | 7 | Bytes written by the host since the last pointer reset |
| ctl_c2h_we | input | 1 | Response buffer write enable |
| ctl_c2h_addr | input | 6 | Response buffer write address |
| ctl_c2h_data | input | 8 | Response byte |
| ctl_status | output | 8 | Current flag register, same layout as offset 0 |
| ctl_hw_reset | output | 1 | Mask register bit 7 |

## Verification
The assertions assume that the host issues single-cycle accesses and that the design leaves reset through its internal release stage before the first access. They also assume that `ctl_set_bbusy` and `ctl_clr_bbusy` are never pulsed together. The bench drives every input at the falling edge and holds it for one full cycle. It waits several cycles after releasing reset, and it never pairs the two B_BUSY pulses. Its flag vectors are run back to back, so that every set, clear and toggle rule, together with each same-cycle priority, is seen from a known prior state.

// File: rtl/bt_window_pkg.sv
package bt_window_pkg;
  typedef enum logic [1:0] {
    OFF_STAT = 2'd0,
    OFF_DATA = 2'd1,
    OFF_MASK = 2'd2,
    OFF_RSVD = 2'd3
  } win_off_e;

  localparam int BIT_CLR_WR = 0;
  localparam int BIT_CLR_RD = 1;
  localparam int BIT_H2B    = 2;
  localparam int BIT_B2H    = 3;
  localparam int BIT_SMS    = 4;
  localparam int BIT_OEM    = 5;
  localparam int BIT_HBUSY  = 6;
  localparam int BIT_BBUSY  = 7;
  localparam int BIT_HWRST  = 7;
endpackage

// File: rtl/bt_ptr.sv
module bt_ptr #(
  parameter int LIMIT = 64,
  localparam int PW = $clog2(LIMIT) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [PW-1:0] ptr,
  output logic          at_end
);
  logic [PW-1:0] ptr_d;
  logic          ptr_en;

  assign at_end = (ptr == PW'(LIMIT));

  always_comb begin
    ptr_en = clr | (adv & ~at_end);
    ptr_d  = ptr;
    if (clr) ptr_d = '0;
    else if (adv & ~at_end) ptr_d = ptr + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (ptr_en) ptr <= ptr_d;
  end
endmodule

// File: rtl/bt_h2b_buf.sv
module bt_h2b_buf #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_clr,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic [PW-1:0] count
);
  logic [7:0] mem [DEPTH];
  logic       at_end;
  logic       mem_we;

  bt_ptr #(.LIMIT(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(ptr_clr), .adv(wr_en),
    .ptr(count), .at_end(at_end)
  );

  assign mem_we = wr_en & ~at_end;

  always_ff @(posedge clk) begin
    if (mem_we) mem[count[AW-1:0]] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/bt_c2h_buf.sv
module bt_c2h_buf #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_clr,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data
);
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] rptr;
  logic          at_end;

  bt_ptr #(.LIMIT(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(ptr_clr), .adv(rd_en),
    .ptr(rptr), .at_end(at_end)
  );

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = at_end ? 8'h00 : mem[rptr[AW-1:0]];
endmodule

// File: rtl/bt_flags.sv
module bt_flags
  import bt_window_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stat_we,
  input  logic [6:2] wbits,
  input  logic       ctl_set_b2h,
  input  logic       ctl_set_sms,
  input  logic       ctl_set_oem,
  input  logic       ctl_set_bbusy,
  input  logic       ctl_clr_bbusy,
  input  logic       ctl_clr_h2b,
  output logic [7:0] status
);
  logic h2b_q, b2h_q, sms_q, oem_q, hbusy_q, bbusy_q;
  logic h2b_d, b2h_d, sms_d, oem_d, hbusy_d, bbusy_d;
  logic [6:2] hw1;

  assign hw1 = wbits & {5{stat_we}};

  always_comb begin
    h2b_d   = (h2b_q & ~ctl_clr_h2b) | hw1[BIT_H2B];
    b2h_d   = (b2h_q & ~hw1[BIT_B2H]) | ctl_set_b2h;
    sms_d   = (sms_q & ~hw1[BIT_SMS]) | ctl_set_sms;
    oem_d   = (oem_q & ~hw1[BIT_OEM]) | ctl_set_oem;
    hbusy_d = hbusy_q ^ hw1[BIT_HBUSY];
    bbusy_d = (bbusy_q & ~ctl_clr_bbusy) | ctl_set_bbusy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h2b_q   <= 1'b0;
      b2h_q   <= 1'b0;
      sms_q   <= 1'b0;
      oem_q   <= 1'b0;
      hbusy_q <= 1'b0;
      bbusy_q <= 1'b0;
    end else begin
      h2b_q   <= h2b_d;
      b2h_q   <= b2h_d;
      sms_q   <= sms_d;
      oem_q   <= oem_d;
      hbusy_q <= hbusy_d;
      bbusy_q <= bbusy_d;
    end
  end

  always_comb begin
    status            = '0;
    status[BIT_H2B]   = h2b_q;
    status[BIT_B2H]   = b2h_q;
    status[BIT_SMS]   = sms_q;
    status[BIT_OEM]   = oem_q;
    status[BIT_HBUSY] = hbusy_q;
    status[BIT_BBUSY] = bbusy_q;
  end
endmodule

// File: rtl/bt_window.sv
module bt_window
  import bt_window_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_cs,
  input  logic          host_we,
  input  logic [1:0]    host_addr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  input  logic          ctl_set_b2h,
  input  logic          ctl_set_sms,
  input  logic          ctl_set_oem,
  input  logic          ctl_set_bbusy,
  input  logic          ctl_clr_bbusy,
  input  logic          ctl_clr_h2b,
  input  logic [AW-1:0] ctl_h2b_addr,
  output logic [7:0]    ctl_h2b_data,
  output logic [PW-1:0] ctl_h2b_count,
  input  logic          ctl_c2h_we,
  input  logic [AW-1:0] ctl_c2h_addr,
  input  logic [7:0]    ctl_c2h_data,
  output logic [7:0]    ctl_status,
  output logic          ctl_hw_reset
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       acc_wr, acc_rd;
  logic       stat_we, data_we, mask_we, data_rd;
  logic       clr_wr_ptr, clr_rd_ptr;
  logic [7:0] mask_q;
  logic [7:0] c2h_byte;
  logic [7:0] rdata_d;
  win_off_e   off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign off     = win_off_e'(host_addr);
  assign acc_wr  = host_cs & host_we;
  assign acc_rd  = host_cs & ~host_we;
  assign stat_we = acc_wr & (off == OFF_STAT);
  assign data_we = acc_wr & (off == OFF_DATA);
  assign mask_we = acc_wr & (off == OFF_MASK);
  assign data_rd = acc_rd & (off == OFF_DATA);

  assign clr_wr_ptr = stat_we & host_wdata[BIT_CLR_WR];
  assign clr_rd_ptr = stat_we & host_wdata[BIT_CLR_RD];

  bt_flags u_flags (
    .clk(clk), .rst_n(rst_sync_n),
    .stat_we(stat_we), .wbits(host_wdata[6:2]),
    .ctl_set_b2h(ctl_set_b2h), .ctl_set_sms(ctl_set_sms),
    .ctl_set_oem(ctl_set_oem), .ctl_set_bbusy(ctl_set_bbusy),
    .ctl_clr_bbusy(ctl_clr_bbusy), .ctl_clr_h2b(ctl_clr_h2b),
    .status(ctl_status)
  );

  bt_h2b_buf #(.DEPTH(DEPTH)) u_h2b (
    .clk(clk), .rst_n(rst_sync_n),
    .ptr_clr(clr_wr_ptr), .wr_en(data_we), .wr_data(host_wdata),
    .rd_addr(ctl_h2b_addr), .rd_data(ctl_h2b_data), .count(ctl_h2b_count)
  );

  bt_c2h_buf #(.DEPTH(DEPTH)) u_c2h (
    .clk(clk), .rst_n(rst_sync_n),
    .ptr_clr(clr_rd_ptr), .rd_en(data_rd), .rd_data(c2h_byte),
    .wr_en(ctl_c2h_we), .wr_addr(ctl_c2h_addr), .wr_data(ctl_c2h_data)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) mask_q <= '0;
    else if (mask_we) mask_q <= host_wdata;
  end
  assign ctl_hw_reset = mask_q[BIT_HWRST];

  always_comb begin
    unique case (off)
      OFF_STAT: rdata_d = ctl_status;
      OFF_DATA: rdata_d = c2h_byte;
      OFF_MASK: rdata_d = mask_q;
      default:  rdata_d = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) host_rdata <= '0;
    else if (acc_rd) host_rdata <= rdata_d;
  end
endmodule

// File: rtl/bt_window_chk.sv
module bt_window_chk #(
  parameter int DEPTH = 64,
  localparam int PW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_cs,
  input logic          host_we,
  input logic [1:0]    host_addr,
  input logic [7:0]    host_wdata,
  input logic [7:0]    host_rdata,
  input logic          ctl_set_b2h,
  input logic          ctl_set_sms,
  input logic          ctl_set_oem,
  input logic          ctl_set_bbusy,
  input logic          ctl_clr_bbusy,
  input logic          ctl_clr_h2b,
  input logic [PW-1:0] ctl_h2b_count,
  input logic [7:0]    ctl_status
);
  logic stat_wr, no_ctl;
  assign stat_wr = host_cs & host_we & (host_addr == 2'd0);
  assign no_ctl  = ~(ctl_set_b2h | ctl_set_sms | ctl_set_oem |
                     ctl_set_bbusy | ctl_clr_bbusy | ctl_clr_h2b);

  // R2
  a_r2_zero_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && host_wdata == 8'h00 && no_ctl) |=> $stable(ctl_status));
  // R2
  a_r2_status_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cs && !host_we && host_addr == 2'd0) |=> host_rdata == $past(ctl_status));
  // R3
  a_r3_hbusy_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && host_wdata[6]) |=> ctl_status[6] != $past(ctl_status[6]));
  // R4
  a_r4_h2b_host_set: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && host_wdata[2]) |=> ctl_status[2]);
  // R5
  a_r5_b2h_ctl_set: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_set_b2h |=> ctl_status[3]);
  // R6
  a_r6_bbusy_host_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !ctl_set_bbusy && !ctl_clr_bbusy) |=> ctl_status[7] == $past(ctl_status[7]));
  // R7
  a_r7_count_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cs && host_we && host_addr == 2'd1 && ctl_h2b_count < PW'(DEPTH))
      |=> ctl_h2b_count == $past(ctl_h2b_count) + PW'(1));
  // R10
  a_r10_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_h2b_count <= PW'(DEPTH));
endmodule

bind bt_window bt_window_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .host_cs(host_cs), .host_we(host_we),
  .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .ctl_set_b2h(ctl_set_b2h), .ctl_set_sms(ctl_set_sms), .ctl_set_oem(ctl_set_oem),
  .ctl_set_bbusy(ctl_set_bbusy), .ctl_clr_bbusy(ctl_clr_bbusy),
  .ctl_clr_h2b(ctl_clr_h2b), .ctl_h2b_count(ctl_h2b_count), .ctl_status(ctl_status)
);

// File: tb/bt_window_tb.sv
module bt_window_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_cs, host_we;
  logic [1:0] host_addr;
  logic [7:0] host_wdata, host_rdata;
  logic       ctl_set_b2h, ctl_set_sms, ctl_set_oem;
  logic       ctl_set_bbusy, ctl_clr_bbusy, ctl_clr_h2b;
  logic [5:0] ctl_h2b_addr;
  logic [7:0] ctl_h2b_data;
  logic [6:0] ctl_h2b_count;
  logic       ctl_c2h_we;
  logic [5:0] ctl_c2h_addr;
  logic [7:0] ctl_c2h_data;
  logic [7:0] ctl_status;
  logic       ctl_hw_reset;

  int errors = 0;
  int checks = 0;
  logic [7:0] rd;

  always #2 clk = ~clk;

  bt_window u_dut (.*);

  // {host status write data, ctl {b2h,sms,oem,set_bb,clr_bb,clr_h2b}, expected status}
  localparam int NV = 17;
  localparam logic [21:0] VEC [NV] = '{
    {8'h40, 6'b000000, 8'h40},
    {8'h04, 6'b000000, 8'h44},
    {8'h00, 6'b000000, 8'h44},
    {8'h00, 6'b100000, 8'h4C},
    {8'h08, 6'b000000, 8'h44},
    {8'h00, 6'b011000, 8'h74},
    {8'h10, 6'b000000, 8'h64},
    {8'h20, 6'b010000, 8'h54},
    {8'h10, 6'b010000, 8'h54},
    {8'h80, 6'b000000, 8'h54},
    {8'h00, 6'b000100, 8'hD4},
    {8'h80, 6'b000000, 8'hD4},
    {8'h04, 6'b000001, 8'hD4},
    {8'h00, 6'b000001, 8'hD0},
    {8'h40, 6'b000010, 8'h10},
    {8'h13, 6'b000000, 8'h00},
    {8'hFF, 6'b000000, 8'h44}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic ctl_idle();
    {ctl_set_b2h, ctl_set_sms, ctl_set_oem, ctl_set_bbusy, ctl_clr_bbusy, ctl_clr_h2b} = '0;
    ctl_c2h_we = 1'b0;
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    host_cs = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_cs = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] a, output logic [7:0] d);
    host_cs = 1'b1; host_we = 1'b0; host_addr = a;
    @(negedge clk);
    host_cs = 1'b0;
    d = host_rdata;
  endtask

  task automatic c2h_load(input logic [5:0] a, input logic [7:0] d);
    ctl_c2h_we = 1'b1; ctl_c2h_addr = a; ctl_c2h_data = d;
    @(negedge clk);
    ctl_c2h_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    host_cs = 0; host_we = 0; host_addr = 0; host_wdata = 0;
    ctl_h2b_addr = 0; ctl_c2h_addr = 0; ctl_c2h_data = 0;
    ctl_idle();
    @(negedge clk);
    do_reset();

    // R1 reset state
    chk("R1 status", ctl_status, 8'h00);
    chk("R1 rdata", host_rdata, 8'h00);
    chk("R1 count", ctl_h2b_count, 7'd0);
    chk("R1 hw_reset", ctl_hw_reset, 1'b0);

    // Flag vector table: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      {ctl_set_b2h, ctl_set_sms, ctl_set_oem, ctl_set_bbusy, ctl_clr_bbusy, ctl_clr_h2b} = VEC[i][13:8];
      host_wr(2'd0, VEC[i][21:14]);
      ctl_idle();
      host_rd(2'd0, rd);
      chk($sformatf("R2 R3 R4 R5 R6 flag vector %0d", i), rd, VEC[i][7:0]);
    end

    // R7 request buffer
    host_wr(2'd0, 8'h01);
    host_wr(2'd1, 8'hA1);
    host_wr(2'd1, 8'hB2);
    host_wr(2'd1, 8'hC3);
    chk("R7 count", ctl_h2b_count, 7'd3);
    ctl_h2b_addr = 6'd1; #1;
    chk("R7 data at 1", ctl_h2b_data, 8'hB2);

    // R9 write pointer reset
    host_wr(2'd0, 8'h01);
    chk("R9 write ptr cleared", ctl_h2b_count, 7'd0);
    host_wr(2'd1, 8'h5A);
    ctl_h2b_addr = 6'd0; #1;
    chk("R9 rewrite at 0", ctl_h2b_data, 8'h5A);

    // R10 write saturation
    host_wr(2'd0, 8'h01);
    for (int i = 0; i < 66; i++) host_wr(2'd1, 8'(i));
    chk("R10 count stops", ctl_h2b_count, 7'd64);
    ctl_h2b_addr = 6'd63; #1;
    chk("R10 last slot", ctl_h2b_data, 8'd63);
    ctl_h2b_addr = 6'd0; #1;
    chk("R10 no wrap", ctl_h2b_data, 8'd0);

    // R8 response buffer
    for (int i = 0; i < 64; i++) c2h_load(6'(i), 8'(8'h80 + i));
    host_wr(2'd0, 8'h02);
    host_rd(2'd1, rd); chk("R8 first byte", rd, 8'h80);
    host_rd(2'd1, rd); chk("R8 second byte", rd, 8'h81);
    host_wr(2'd0, 8'h02);
    host_rd(2'd1, rd); chk("R9 read ptr cleared", rd, 8'h80);

    // R10 read saturation
    for (int i = 1; i < 64; i++) host_rd(2'd1, rd);
    chk("R10 last read byte", rd, 8'hBF);
    host_rd(2'd1, rd); chk("R10 read past end", rd, 8'h00);
    host_rd(2'd1, rd); chk("R10 still at end", rd, 8'h00);

    // R11 mask register
    host_wr(2'd2, 8'h80);
    chk("R11 hw_reset set", ctl_hw_reset, 1'b1);
    host_rd(2'd2, rd); chk("R11 readback", rd, 8'h80);
    host_wr(2'd2, 8'h05);
    chk("R11 hw_reset clear", ctl_hw_reset, 1'b0);
    host_rd(2'd2, rd); chk("R11 readback 2", rd, 8'h05);

    // R2: never 0xFF at offset 0 even with all flags up
    host_wr(2'd2, 8'hFF);
    ctl_set_b2h = 1; ctl_set_sms = 1; ctl_set_oem = 1; ctl_set_bbusy = 1;
    host_wr(2'd0, 8'h07);
    ctl_idle();
    host_rd(2'd0, rd); chk("R2 status not all ones", rd, 8'hFC);

    // R12 reserved offset
    host_wr(2'd3, 8'h77);
    host_rd(2'd3, rd); chk("R12 reserved reads zero", rd, 8'h00);
    host_rd(2'd2, rd); chk("R12 mask untouched", rd, 8'hFF);
    host_rd(2'd0, rd); chk("R12 status untouched", rd, 8'hFC);

    // R1 reset mid-run
    do_reset();
    chk("R1 status after reset", ctl_status, 8'h00);
    chk("R1 count after reset", ctl_h2b_count, 7'd0);
    host_rd(2'd2, rd); chk("R1 mask after reset", rd, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule